// File: doc/BRIEF.md
# I2C Slave Masked Address Matcher

This block decides whether the address phase of an I2C transfer is meant for this slave. The serial front end hands it each byte it has shifted in, with a one-cycle valid strobe, plus one-cycle indications of START (including repeated START) and STOP. The block compares the address byte or bytes against a programmed slave address. A programmable mask turns selected bit positions into don't-care positions, so one slave can answer a whole range of addresses. When the address matches, the block raises a one-cycle acknowledge request and reports the read/write direction.

Both 7-bit and 10-bit addressing are supported. In 10-bit mode the first byte carries the fixed prefix and the two upper address bits, which are always compared exactly. The masked comparison is then applied to the second byte. A small register port holds the mode field, the address and mask pair, and the two upper address bits. The mask has no location of its own: it is reached through the address location while a dedicated mode value is selected.

The sequencer has four states. IDLE waits for a START. ADDR expects the first address byte. EXT expects the second byte of a 10-bit address. SKIP ignores the rest of the transfer. The transitions are:
- START, from any state, goes to ADDR.
- STOP goes to IDLE.
- An address byte in ADDR goes to SKIP, or to EXT when a 10-bit first byte matches.
- A byte in EXT goes to SKIP.

Top module: `i2c_addr_mask_match`

## Requirements
- R1: After reset:
  - the mode field reads 0;
  - the address reads 00h;
  - the upper-address register reads 0;
  - the mask reads FFh;
  - ack_req and rw_flag are 0.
- R2: The register locations are:
  - location 0 holds the mode in bits 3:0, and its upper read bits are 0;
  - location 2 holds the two upper address bits in bits 1:0;
  - location 1 reads and writes the mask while the mode is 1001b, and the address otherwise.
- R3: In mode 0110b (7-bit slave), the first byte after START is compared on bits 7:1. On a match, ack_req pulses high for exactly the cycle after the byte strobe, and rw_flag takes bit 0 of that byte in the same cycle.
- R4: A mask bit of 0 makes the corresponding address bit a don't-care, and a mask bit of 1 demands equality. For example, address A0h with mask F2h acknowledges exactly the bytes whose upper seven bits give A0h, A4h, A8h or ACh.
- R5: With the reset mask, only the exact programmed address is acknowledged.
- R6: In mode 0111b (10-bit slave), the first byte must equal 11110b, then the upper address bits, then R/W. These bits are compared exactly whatever the mask holds, and no acknowledge is raised for the first byte.
- R7: In 10-bit mode, after a matching first byte, the second byte is compared on all 8 bits under the mask. On a match, ack_req pulses the cycle after it, and rw_flag takes bit 0 of the first byte.
- R8: Only the address byte or bytes directly after a START are examined. Later bytes cause no acknowledge until the next START.
- R9: A repeated START discards a partial 10-bit match and treats the next byte as a first byte. After a STOP, bytes are ignored.
- R10: Modes other than 0110b and 0111b never raise ack_req.
- R11: When START or STOP arrives in the same cycle as a byte strobe, the condition wins and the byte is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_seen | input | 1 | One-cycle START or repeated START indication |
| stop_seen | input | 1 | One-cycle STOP indication |
| rx_valid | input | 1 | Byte strobe for rx_byte |
| rx_byte | input | 8 | Byte shifted in from the bus |
| reg_wr | input | 1 | Register write strobe |
| reg_loc | input | LOC_W | Register location select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_loc |
| ack_req | output | 1 | One-cycle acknowledge request |
| rw_flag | output | 1 | Direction of the last acknowledged address (1 = read) |

## Verification
The hardest situation to reach is a 10-bit match that is interrupted. A matching first byte has to be followed by a repeated START or a STOP before the second byte, and the interrupted transfer must then leave no trace. The stimulus builds these sequences explicitly. It also drives START and a byte strobe in the same cycle, which a normal bus front end would rarely produce. A full sweep of all 256 first bytes under a mask checks the exact set of acknowledged addresses. A behavioural model compares ack_req and rw_flag on every clock.

// File: rtl/i2c_amm_pkg.sv
package i2c_amm_pkg;
    localparam int BYTE_W  = 8;
    localparam int MODE_W  = 4;
    localparam int UPPER_W = 2;
    localparam int PFX_W   = BYTE_W - UPPER_W - 1;

    localparam logic [MODE_W-1:0] MODE_SLV7    = 4'b0110;
    localparam logic [MODE_W-1:0] MODE_SLV10   = 4'b0111;
    localparam logic [MODE_W-1:0] MODE_MASKSEL = 4'b1001;

    localparam logic [PFX_W-1:0] TEN_PREFIX = 5'b11110;

    localparam logic [1:0] LOC_CTRL  = 2'd0;
    localparam logic [1:0] LOC_ADDR  = 2'd1;
    localparam logic [1:0] LOC_UPPER = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_EXT,
        ST_SKIP
    } amm_state_t;
endpackage

// File: rtl/i2c_amm_regs.sv
module i2c_amm_regs
    import i2c_amm_pkg::*;
#(
    parameter int LOC_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [LOC_W-1:0]   reg_loc,
    input  logic [BYTE_W-1:0]  reg_wdata,
    output logic [BYTE_W-1:0]  reg_rdata,
    output logic [MODE_W-1:0]  mode_o,
    output logic [BYTE_W-1:0]  addr_o,
    output logic [BYTE_W-1:0]  mask_o,
    output logic [UPPER_W-1:0] upper_o
);
    logic mask_sel;
    assign mask_sel = (mode_o == MODE_MASKSEL);

    // Registers: the mask shares location 1 with the address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_o  <= '0;
            addr_o  <= '0;
            mask_o  <= '1;
            upper_o <= '0;
        end else if (reg_wr) begin
            case (reg_loc)
                LOC_CTRL:  mode_o <= reg_wdata[MODE_W-1:0];
                LOC_ADDR: begin
                    if (mask_sel) mask_o <= reg_wdata;
                    else          addr_o <= reg_wdata;
                end
                LOC_UPPER: upper_o <= reg_wdata[UPPER_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (reg_loc)
            LOC_CTRL:  reg_rdata = {{(BYTE_W-MODE_W){1'b0}}, mode_o};
            LOC_ADDR:  reg_rdata = mask_sel ? mask_o : addr_o;
            LOC_UPPER: reg_rdata = {{(BYTE_W-UPPER_W){1'b0}}, upper_o};
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/i2c_amm_cmp.sv
module i2c_amm_cmp
    import i2c_amm_pkg::*;
(
    input  logic [BYTE_W-1:0]  rx_byte,
    input  logic [BYTE_W-1:0]  addr,
    input  logic [BYTE_W-1:0]  mask,
    input  logic [UPPER_W-1:0] upper,
    output logic               hit7,
    output logic               hit10_hi,
    output logic               hit10_lo
);
    logic [BYTE_W-1:0] diff;

    // A bit counts as a mismatch only where the mask demands equality
    for (genvar gi = 0; gi < BYTE_W; gi++) begin : g_bit
        assign diff[gi] = (rx_byte[gi] ^ addr[gi]) & mask[gi];
    end

    assign hit7     = ~|diff[BYTE_W-1:1];
    assign hit10_lo = ~|diff;
    // Prefix and upper address bits are never masked
    assign hit10_hi = (rx_byte[BYTE_W-1 -: PFX_W] == TEN_PREFIX) &&
                      (rx_byte[UPPER_W:1] == upper);
endmodule

// File: rtl/i2c_amm_fsm.sv
module i2c_amm_fsm
    import i2c_amm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_seen,
    input  logic              stop_seen,
    input  logic              rx_valid,
    input  logic              rw_bit,
    input  logic [MODE_W-1:0] mode,
    input  logic              hit7,
    input  logic              hit10_hi,
    input  logic              hit10_lo,
    output logic              ack_req,
    output logic              rw_flag,
    output logic              ext_pending
);
    amm_state_t state_q, state_d;
    logic ack_d, rw_d, prw_q, prw_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and output decisions
    always_comb begin
        state_d = state_q;
        ack_d   = 1'b0;
        rw_d    = rw_flag;
        prw_d   = prw_q;
        if (start_seen) begin
            state_d = ST_ADDR;
        end else if (stop_seen) begin
            state_d = ST_IDLE;
        end else if (rx_valid) begin
            unique case (state_q)
                ST_IDLE: ;
                ST_ADDR: begin
                    state_d = ST_SKIP;
                    if (mode == MODE_SLV7) begin
                        if (hit7) begin
                            ack_d = 1'b1;
                            rw_d  = rw_bit;
                        end
                    end else if (mode == MODE_SLV10 && hit10_hi) begin
                        state_d = ST_EXT;
                        prw_d   = rw_bit;
                    end
                end
                ST_EXT: begin
                    state_d = ST_SKIP;
                    if (mode == MODE_SLV10 && hit10_lo) begin
                        ack_d = 1'b1;
                        rw_d  = prw_q;
                    end
                end
                ST_SKIP: ;
            endcase
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_req <= 1'b0;
            rw_flag <= 1'b0;
            prw_q   <= 1'b0;
        end else begin
            ack_req <= ack_d;
            rw_flag <= rw_d;
            prw_q   <= prw_d;
        end
    end

    assign ext_pending = (state_q == ST_EXT);
endmodule

// File: rtl/i2c_addr_mask_match.sv
module i2c_addr_mask_match
    import i2c_amm_pkg::*;
#(
    parameter int LOC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_seen,
    input  logic             stop_seen,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    input  logic             reg_wr,
    input  logic [LOC_W-1:0] reg_loc,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    output logic             ack_req,
    output logic             rw_flag
);
    logic [MODE_W-1:0]  mode_q;
    logic [BYTE_W-1:0]  addr_q, mask_q;
    logic [UPPER_W-1:0] upper_q;
    logic hit7, hit10_hi, hit10_lo, ext_pending;

    i2c_amm_regs #(.LOC_W(LOC_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_loc(reg_loc),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mode_o(mode_q),
        .addr_o(addr_q), .mask_o(mask_q), .upper_o(upper_q)
    );

    i2c_amm_cmp cmp_i (
        .rx_byte(rx_byte), .addr(addr_q), .mask(mask_q), .upper(upper_q),
        .hit7(hit7), .hit10_hi(hit10_hi), .hit10_lo(hit10_lo)
    );

    i2c_amm_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .start_seen(start_seen), .stop_seen(stop_seen),
        .rx_valid(rx_valid), .rw_bit(rx_byte[0]), .mode(mode_q), .hit7(hit7),
        .hit10_hi(hit10_hi), .hit10_lo(hit10_lo), .ack_req(ack_req),
        .rw_flag(rw_flag), .ext_pending(ext_pending)
    );
endmodule

// File: rtl/i2c_amm_chk.sv
module i2c_amm_chk
    import i2c_amm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start_seen,
    input logic              stop_seen,
    input logic              rx_valid,
    input logic              ack_req,
    input logic [MODE_W-1:0] mode,
    input logic              ext_pending
);
    p_ack_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |=> !ack_req);

    p_ack_after_byte_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |-> ($past(rx_valid) && !$past(start_seen) && !$past(stop_seen)));

    p_ack_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |-> ($past(mode) == MODE_SLV7 || $past(mode) == MODE_SLV10));

    p_ten_second_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && $past(mode) == MODE_SLV10) |-> $past(ext_pending));

    p_start_drops_ext_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_seen |=> !ext_pending);

    p_stop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_seen |=> (!ack_req && !ext_pending));
endmodule

bind i2c_addr_mask_match i2c_amm_chk chk_i (
    .clk(clk), .rst_n(rst_n), .start_seen(start_seen), .stop_seen(stop_seen),
    .rx_valid(rx_valid), .ack_req(ack_req), .mode(mode_q),
    .ext_pending(ext_pending)
);

// File: tb/i2c_addr_mask_match_tb_top.sv
module i2c_addr_mask_match_tb_top;
    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_seen = 1'b0, stop_seen = 1'b0, rx_valid = 1'b0, reg_wr = 1'b0;
    logic [7:0] rx_byte = 8'h00, reg_wdata = 8'h00;
    logic [1:0] reg_loc = 2'd0;
    logic [7:0] reg_rdata;
    logic ack_req, rw_flag;

    int n_chk = 0, n_bad = 0;
    string cur_req = "R1";

    always #(CLK_P/2) clk = ~clk;

    i2c_addr_mask_match dut_i (
        .clk(clk), .rst_n(rst_n), .start_seen(start_seen), .stop_seen(stop_seen),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .reg_wr(reg_wr), .reg_loc(reg_loc),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ack_req(ack_req),
        .rw_flag(rw_flag)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    logic [3:0] m_mode = 4'h0;
    logic [7:0] m_addr = 8'h00, m_mask = 8'hFF;
    logic [1:0] m_upper = 2'b00;
    int m_phase = 0;  // 0 idle, 1 first byte, 2 second byte, 3 ignore
    logic m_prw = 1'b0, e_ack = 1'b0, e_rw = 1'b0;

    function automatic bit masked_eq(logic [7:0] b, int lo);
        for (int i = lo; i < 8; i++)
            if (m_mask[i] && (b[i] != m_addr[i])) return 1'b0;
        return 1'b1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_addr = 0; m_mask = 8'hFF; m_upper = 0;
            m_phase = 0; m_prw = 0; e_ack = 0; e_rw = 0;
        end else begin
            e_ack = 0;
            if (start_seen) m_phase = 1;
            else if (stop_seen) m_phase = 0;
            else if (rx_valid) begin
                if (m_phase == 1) begin
                    m_phase = 3;
                    if (m_mode == 4'd6) begin
                        if (masked_eq(rx_byte, 1)) begin e_ack = 1; e_rw = rx_byte[0]; end
                    end else if (m_mode == 4'd7 && rx_byte[7:3] == 5'h1E &&
                                 rx_byte[2:1] == m_upper) begin
                        m_phase = 2; m_prw = rx_byte[0];
                    end
                end else if (m_phase == 2) begin
                    m_phase = 3;
                    if (m_mode == 4'd7 && masked_eq(rx_byte, 0)) begin
                        e_ack = 1; e_rw = m_prw;
                    end
                end
            end
            if (reg_wr) begin
                if (reg_loc == 0) m_mode = reg_wdata[3:0];
                else if (reg_loc == 1) begin
                    if (m_mode == 4'd9) m_mask = reg_wdata; else m_addr = reg_wdata;
                end else if (reg_loc == 2) m_upper = reg_wdata[1:0];
            end
        end
    end

    always @(posedge clk) begin
        #2;
        chk({cur_req, " ack_req vs model"}, ack_req, e_ack);
        chk({cur_req, " rw_flag vs model"}, rw_flag, e_rw);
    end

    task automatic wr(logic [1:0] loc, logic [7:0] d);
        @(negedge clk); reg_wr = 1; reg_loc = loc; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(logic [1:0] loc, logic [7:0] exp, string tag);
        @(negedge clk); reg_loc = loc;
        #1 chk(tag, reg_rdata, exp);
    endtask

    task automatic cond(bit is_start);
        @(negedge clk);
        if (is_start) start_seen = 1; else stop_seen = 1;
        @(negedge clk); start_seen = 0; stop_seen = 0;
    endtask

    task automatic send(logic [7:0] b, output logic a, output logic r);
        @(negedge clk); rx_byte = b; rx_valid = 1;
        @(negedge clk); rx_valid = 0; a = ack_req; r = rw_flag;
    endtask

    task automatic addr7(logic [7:0] b, logic exp_ack, string tag);
        logic a, r;
        cond(1);
        send(b, a, r);
        chk(tag, a, exp_ack);
        if (exp_ack) chk({tag, " rw"}, r, b[0]);
    endtask

    initial begin
        #(CLK_P * 60000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic a, r;
        int hits;
        repeat (3) @(negedge clk);
        // R1 reset values
        chk("R1 ack_req after reset", ack_req, 0);
        chk("R1 rw_flag after reset", rw_flag, 0);
        @(negedge clk); rst_n = 1;
        rd(0, 8'h00, "R1 mode reset");
        rd(1, 8'h00, "R1 address reset");
        rd(2, 8'h00, "R1 upper reset");
        wr(0, 8'h09);
        rd(1, 8'hFF, "R1 mask reset all ones");

        // R2 register map
        cur_req = "R2";
        wr(0, 8'hFF);
        rd(0, 8'h0F, "R2 mode field width");
        wr(0, 8'h00);
        wr(1, 8'hA0);
        rd(1, 8'hA0, "R2 address via location 1");
        wr(2, 8'hFF);
        rd(2, 8'h03, "R2 upper field width");
        wr(2, 8'h00);

        // R5 default mask: exact match only
        cur_req = "R5";
        wr(0, 8'h06);
        addr7(8'hA0, 1, "R5 exact write");
        addr7(8'hA1, 1, "R3 exact read rw=1");
        addr7(8'hA4, 0, "R5 near miss A4");
        addr7(8'h20, 0, "R5 top bit miss");

        // R4 mask example, full sweep
        cur_req = "R4";
        wr(0, 8'h09);
        wr(1, 8'hF2);
        rd(1, 8'hF2, "R2 mask via location 1 in mode 1001");
        wr(0, 8'h00);
        rd(1, 8'hA0, "R2 address unchanged by mask write");
        wr(0, 8'h06);
        hits = 0;
        for (int b = 0; b < 256; b++) begin
            cond(1);
            send(b[7:0], a, r);
            chk("R4 sweep byte", a, ((b[7:0] & 8'hF2) == 8'hA0));
            if (a) hits++;
        end
        chk("R4 number of acknowledged bytes", hits, 8);

        // R8 later bytes ignored
        cur_req = "R8";
        cond(1);
        send(8'hA4, a, r); chk("R8 first byte ack", a, 1);
        send(8'hA8, a, r); chk("R8 second byte ignored", a, 0);

        // R11 condition wins over simultaneous byte
        cur_req = "R11";
        @(negedge clk); start_seen = 1; rx_valid = 1; rx_byte = 8'hA0;
        @(negedge clk); start_seen = 0; rx_valid = 0;
        chk("R11 byte with START ignored", ack_req, 0);
        send(8'hAC, a, r); chk("R11 next byte is address", a, 1);

        // R10 other modes never acknowledge
        cur_req = "R10";
        wr(0, 8'h09); addr7(8'hA0, 0, "R10 mode 1001");
        wr(0, 8'h00); addr7(8'hA0, 0, "R10 mode 0000");

        // R6/R7 10-bit addressing
        cur_req = "R7";
        wr(0, 8'h09); wr(1, 8'hFF);
        wr(0, 8'h00); wr(1, 8'h35);
        wr(2, 8'h02);
        wr(0, 8'h07);
        cond(1);
        send(8'hF5, a, r); chk("R6 no ack on first byte", a, 0);
        send(8'h35, a, r); chk("R7 second byte match", a, 1);
        chk("R7 rw from first byte", r, 1);
        cond(1);
        send(8'hF4, a, r);
        send(8'h34, a, r); chk("R7 low bit mismatch", a, 0);
        cond(1);
        send(8'hF3, a, r);
        send(8'h35, a, r); chk("R6 upper bits mismatch", a, 0);
        wr(0, 8'h09); wr(1, 8'h00); wr(0, 8'h07);
        cond(1);
        send(8'hF3, a, r);
        send(8'h99, a, r); chk("R6 upper bits not masked", a, 0);
        cond(1);
        send(8'hF4, a, r);
        send(8'h99, a, r); chk("R7 fully masked low byte", a, 1);
        chk("R7 rw write", r, 0);

        // R9 repeated START and STOP
        cur_req = "R9";
        cond(1);
        send(8'hF5, a, r);
        cond(1);
        send(8'h35, a, r); chk("R9 restart discards partial", a, 0);
        cond(1);
        send(8'hF5, a, r);
        cond(0);
        send(8'h35, a, r); chk("R9 stop discards partial", a, 0);
        send(8'hF5, a, r); chk("R9 byte after stop ignored", a, 0);

        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule